// File: doc/BRIEF.md
# Interleaved Dual-ADC Sample Merger

This block takes the outputs of eight free-running 12-bit converters, already brought into the 125 MHz system clock domain, and turns them into an ordered sample stream. It has two modes. In normal mode each converter is its own channel, sampled once per system cycle. In interleaved mode the converters work in pairs whose sampling clocks are half a period apart. Each pair then forms one channel at twice the rate, so four channels are carried. Each of these channels delivers two samples per system cycle, and the block puts them in time order: the 0-degree sample first, the 180-degree sample second.

Each converter has a fixed pipeline delay of five sample clocks. The block subtracts this delay from a free-running cycle counter, so the timestamp on each output word marks the moment the sample was taken. The counter starts at zero when acquisition is enabled. The five words that arrive first after enable describe instants before that start, so the block withholds them. Timestamps count in 8 ns units in normal mode and in 4 ns units in interleaved mode. The mode is taken from a configuration input, and it is only latched while acquisition is off.

Top module: `interleave_merger`

## Requirements
- R1: After reset, mergedValid, mergedMode, mergedStamp and every slot of mergedData are zero.
- R2: Normal mode (mergedMode=0). Slot i of mergedData (bits 12*i+11 down to 12*i) equals converter i as presented one clock earlier. This holds for all eight slots.
- R3: Interleaved mode (mergedMode=1). Only physical inputs 1, 2, 5 and 6 (converter indices 0, 1, 4, 5) are channel sources. Channel c uses slot 2c for the 0-degree sample from its source converter. It uses slot 2c+1 for the 180-degree sample from the converter two indices above that source (indices 2, 3, 6 or 7). The channels map to sources as c0=0, c1=1, c2=4, c3=5.
- R4: mergedValid stays low for the first 5 clock edges after acqEnable is first seen high. It is high from the sixth edge on, while acqEnable stays high. It goes low on the first edge at which acqEnable is seen low.
- R5: In normal mode the first valid word has mergedStamp 0, and each following valid word increases it by 1 (8 ns units).
- R6: In interleaved mode mergedStamp is the stamp of slot 2c, counted in 4 ns units. It is 0 on the first valid word and increases by 2 per word, so it is always even. Slot 2c+1 implicitly carries stamp+1.
- R7: interleaveSel is latched only on edges where acqEnable is low. A change while acquisition runs has no effect on the mapping or the stamp step until acquisition is stopped.
- R8: While mergedValid is low, mergedData, mergedStamp and mergedMode keep their last values.
- R9: Each new enable restarts the timestamp, so the first valid word after re-enable has stamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| acqEnable | input | 1 | Acquisition run control |
| interleaveSel | input | 1 | Mode request: 1 = paired 250 MHz-equivalent channels |
| convData | input | 96 | Eight 12-bit converter samples, converter i at bits 12*i+11:12*i |
| mergedData | output | 96 | Eight ordered 12-bit output slots |
| mergedValid | output | 1 | Output word holds live, latency-corrected samples |
| mergedStamp | output | 32 | Sample instant of slot 0/2c, in 8 ns (normal) or 4 ns (interleaved) units |
| mergedMode | output | 1 | Mode in which the current word was formed |

## Verification
The bench sweeps both modes with a pattern that is unique per converter and per cycle. A swapped 0/180-degree order or a wrong partner index therefore shows up as a slot mismatch, and so does routing from an inactive input. The enable edge is probed for off-by-one latency handling: if the design withholds four or six words, the count of invalid cycles is wrong, and a stamp that does not start at zero shows that the delay correction is wrong. A mode toggle during a run catches a design that latches the mode bit live. Idle stretches between runs catch outputs that keep updating while invalid, and re-enables catch a counter that fails to restart.

// File: rtl/imerge_pkg.sv
package imerge_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;     // load a new output word this edge
    logic interleave;  // latched mode for the word being loaded
  } merge_strobe_t;

  // Converter feeding an output slot in interleaved mode.
  // Channel c = slot/2 takes source (c/2)*4 + c%2; the odd slot uses the
  // converter two above that source (180-degree partner).
  function automatic int pairSource(input int slot);
    int ch;
    ch = slot / 2;
    return (ch / 2) * 4 + (ch % 2) + 2 * (slot % 2);
  endfunction

endpackage

// File: rtl/merger_ctrl.sv
module merger_ctrl
  import imerge_pkg::*;
#(
  parameter int LAT  = 5,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            acqEnable,
  input  logic            interleaveSel,
  output merge_strobe_t   strb,
  output logic [TS_W-1:0] stampBase,
  output logic            validOut
);

  localparam logic [TS_W-1:0] LAT_T = TS_W'(LAT);

  logic [TS_W-1:0] cycCnt;
  logic            modeReg;
  logic            validReg;
  logic            capture;

  assign capture = acqEnable && (cycCnt >= LAT_T);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt   <= '0;
      modeReg  <= 1'b0;
      validReg <= 1'b0;
    end else begin
      if (!acqEnable) begin
        cycCnt  <= '0;
        modeReg <= interleaveSel;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
      validReg <= capture;
    end
  end

  assign strb.capture    = capture;
  assign strb.interleave = modeReg;
  assign stampBase       = cycCnt - LAT_T;
  assign validOut        = validReg;

  // R4
  fresh_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acqEnable) |=> !validReg);

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(acqEnable) |-> $stable(modeReg));

  // R4
  stop_drops_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acqEnable |=> !validReg);

endmodule

// File: rtl/merger_dp.sv
module merger_dp
  import imerge_pkg::*;
#(
  parameter int NUM_CONV = 8,
  parameter int SAMP_W   = 12,
  parameter int TS_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  merge_strobe_t              strb,
  input  logic [TS_W-1:0]            stampBase,
  input  logic [NUM_CONV*SAMP_W-1:0] convData,
  output logic [NUM_CONV*SAMP_W-1:0] dataOut,
  output logic [TS_W-1:0]            stampOut,
  output logic                       modeOut
);

  localparam int BUS_W = NUM_CONV * SAMP_W;

  logic [SAMP_W-1:0] convArr [NUM_CONV];
  logic [BUS_W-1:0]  slotNext;
  logic [BUS_W-1:0]  dataReg;
  logic [TS_W-1:0]   stampReg;
  logic [TS_W-1:0]   stampNext;
  logic              modeReg;

  for (genvar s = 0; s < NUM_CONV; s++) begin : g_slot
    localparam int SRC_IL = pairSource(s);
    assign convArr[s] = convData[s*SAMP_W +: SAMP_W];
    always_comb begin
      if (strb.interleave) slotNext[s*SAMP_W +: SAMP_W] = convArr[SRC_IL];
      else                 slotNext[s*SAMP_W +: SAMP_W] = convArr[s];
    end
  end

  assign stampNext = strb.interleave ? {stampBase[TS_W-2:0], 1'b0} : stampBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      stampReg <= '0;
      modeReg  <= 1'b0;
    end else if (strb.capture) begin
      dataReg  <= slotNext;
      stampReg <= stampNext;
      modeReg  <= strb.interleave;
    end
  end

  assign dataOut  = dataReg;
  assign stampOut = stampReg;
  assign modeOut  = modeReg;

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(dataReg) && $stable(stampReg) && $stable(modeReg)));

  // R6
  even_stamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.interleave) |=> !stampReg[0]);

endmodule

// File: rtl/interleave_merger.sv
module interleave_merger
  import imerge_pkg::*;
#(
  parameter int NUM_CONV = 8,
  parameter int SAMP_W   = 12,
  parameter int LAT      = 5,
  parameter int TS_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       acqEnable,
  input  logic                       interleaveSel,
  input  logic [NUM_CONV*SAMP_W-1:0] convData,
  output logic [NUM_CONV*SAMP_W-1:0] mergedData,
  output logic                       mergedValid,
  output logic [TS_W-1:0]            mergedStamp,
  output logic                       mergedMode
);

  merge_strobe_t   strb;
  logic [TS_W-1:0] stampBase;

  merger_ctrl #(.LAT(LAT), .TS_W(TS_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .acqEnable    (acqEnable),
    .interleaveSel(interleaveSel),
    .strb         (strb),
    .stampBase    (stampBase),
    .validOut     (mergedValid)
  );

  merger_dp #(.NUM_CONV(NUM_CONV), .SAMP_W(SAMP_W), .TS_W(TS_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stampBase(stampBase),
    .convData (convData),
    .dataOut  (mergedData),
    .stampOut (mergedStamp),
    .modeOut  (mergedMode)
  );

  // R5 R6
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mergedValid && $past(mergedValid)) |->
      (mergedStamp == $past(mergedStamp) + (mergedMode ? TS_W'(2) : TS_W'(1))));

  // R9
  first_stamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mergedValid) |-> (mergedStamp == '0));

endmodule

// File: tb/sim_interleave_merger.sv
module sim_interleave_merger;

  localparam int NC = 8;
  localparam int SW = 12;
  localparam int TW = 32;
  localparam int LATC = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          acqEnable = 1'b0;
  logic          interleaveSel = 1'b0;
  logic [NC*SW-1:0] convData = '0;
  logic [NC*SW-1:0] mergedData;
  logic          mergedValid;
  logic [TW-1:0] mergedStamp;
  logic          mergedMode;

  always #5 clk = ~clk;

  interleave_merger u0 (
    .clk(clk), .rstN(rstN), .acqEnable(acqEnable), .interleaveSel(interleaveSel),
    .convData(convData), .mergedData(mergedData), .mergedValid(mergedValid),
    .mergedStamp(mergedStamp), .mergedMode(mergedMode)
  );

  int errors = 0;
  int checks = 0;
  int gcyc = 0;
  bit finished = 0;

  // bench model state
  int         mCnt = 0;
  bit         mMode = 0;
  bit         mValid = 0;
  longint     mStamp = 0;
  bit         mOutMode = 0;
  logic [SW-1:0] mData [NC];
  logic [SW-1:0] curIn [NC];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int srcFor(input int slot, input bit il);
    int ch;
    if (!il) return slot;
    ch = slot / 2;                         // channel 0..3
    // sources 0,1,4,5 ; odd slot takes partner two above
    return ((ch >= 2) ? 4 : 0) + (ch % 2) + ((slot % 2 == 1) ? 2 : 0);
  endfunction

  // one clock: apply pattern, step model at posedge, compare at negedge
  task automatic step();
    for (int i = 0; i < NC; i++) begin
      curIn[i] = SW'(gcyc * 53 + i * 389 + 17);
      convData[i*SW +: SW] = curIn[i];
    end
    @(posedge clk);
    if (acqEnable) begin
      if (mCnt >= LATC) begin
        mValid = 1;
        mStamp = mMode ? 2 * (mCnt - LATC) : (mCnt - LATC);
        mOutMode = mMode;
        for (int s = 0; s < NC; s++) mData[s] = curIn[srcFor(s, mMode)];
      end else mValid = 0;
      mCnt++;
    end else begin
      mValid = 0;
      mCnt = 0;
      mMode = interleaveSel;
    end
    gcyc++;
    @(negedge clk);
    chk(mergedValid == mValid, "R4", "valid", mergedValid, mValid);
    chk(mergedStamp == TW'(mStamp), mOutMode ? "R6" : "R5", "stamp", mergedStamp, mStamp);
    chk(mergedMode == mOutMode, "R7", "mode", mergedMode, mOutMode);
    for (int s = 0; s < NC; s++)
      chk(mergedData[s*SW +: SW] == mData[s],
          !mValid ? "R8" : (mOutMode ? "R3" : "R2"),
          $sformatf("slot%0d", s), mergedData[s*SW +: SW], mData[s]);
  endtask

  task automatic run(input bit mode, input int onCycles, input int offCycles);
    interleaveSel = mode;
    step();                              // latch mode while idle
    acqEnable = 1'b1;
    for (int k = 0; k < onCycles; k++) step();
    acqEnable = 1'b0;
    for (int k = 0; k < offCycles; k++) step();   // R8 idle hold
  endtask

  initial begin
    for (int s = 0; s < NC; s++) mData[s] = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(mergedValid == 1'b0, "R1", "valid", mergedValid, 0);
    chk(mergedStamp == '0, "R1", "stamp", mergedStamp, 0);
    chk(mergedMode == 1'b0, "R1", "mode", mergedMode, 0);
    chk(mergedData == '0, "R1", "data", 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R5 normal run, R9 re-enable
    run(1'b0, 20, 3);
    run(1'b0, 9, 2);
    // R3 R6 interleaved runs, including a 5-cycle run that never validates (R4)
    run(1'b1, 24, 3);
    run(1'b1, 5, 2);
    run(1'b1, 6, 2);

    // R7: toggle request mid-run; must not take effect until stopped
    interleaveSel = 1'b1;
    step();
    acqEnable = 1'b1;
    for (int k = 0; k < 8; k++) step();
    interleaveSel = 1'b0;
    for (int k = 0; k < 10; k++) step();
    chk(mergedMode == 1'b1, "R7", "mode held during run", mergedMode, 1);
    acqEnable = 1'b0;
    step();
    step();
    acqEnable = 1'b1;
    for (int k = 0; k < 10; k++) step();
    chk(mergedMode == 1'b0, "R7", "mode after restart", mergedMode, 0);
    acqEnable = 1'b0;
    for (int k = 0; k < 3; k++) step();

    // sweep of run lengths in both modes
    for (int m = 0; m < 2; m++)
      for (int len = 3; len < 12; len++) run(m[0], len, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule